// File: doc/BRIEF.md
# Watermark-Driven Serial Flow Control

This block sits beside a serial port and decides, on both directions, when data may flow. On the inbound side it reads the fill level of the receive buffer. When the level climbs to a programmable upper mark, it asks the far end to stop. It does this by dropping the request-to-send line, by sending a stop character, or by both. It lets the far end resume only once the level has drained to a programmable lower mark. The gap between the two marks gives hysteresis. On the outbound side it watches the clear-to-send line and any stop/resume characters that arrive. It holds back new outbound bytes while the far end has asked for a pause. A byte already handed to the serialiser still goes out in full.

The line polarity, the two modes and the buffer split are chosen at run time. The receive buffer gets either the smaller or the larger share of a fixed shared store, and the outbound buffer gets the rest. An overflow of the receive buffer is caught and held in a sticky flag until software clears it. The serialiser and the buffer memory are outside the block. It sees only the level count, an overflow event and the three byte streams.

Top module: `serial_flow_gate`

## Requirements
- R1: After reset the block is not holding the far end off, no control character is pending, the remote side is not paused, `rx_out_valid` and `ovf_flag` are 0, and `tx_in_ready` follows `tx_out_ready`.
- R2: The hold state is set at the first rising edge at which `in_level` is at or above the effective upper mark. The effective upper mark is `cfg_high_mark` capped at the inbound capacity.
- R3: Once set, the hold state stays set while `in_level` is above `cfg_low_mark`. It clears at the first rising edge at which the level is at or below `cfg_low_mark` and below the effective upper mark. When the marks overlap, the upper-mark test wins.
- R4: With `cfg_pol_high`=1 both lines are asserted when high; with 0 they are asserted when low. `rts_pin` is asserted unless hardware mode is on and the hold state is set.
- R5: In hardware mode, a deasserted `cts_pin` stops new outbound data (`tx_in_ready`=0, no data on `tx_out_valid`) after exactly SYNC_STAGES rising edges. Re-assertion resumes the data after the same delay.
- R6: In software mode, the edge that sets the hold state queues the stop code 0x13 and the edge that clears it queues the resume code 0x11. A queued code is offered on `tx_out_*` ahead of any data byte, even while outbound data is paused. It is retired when `tx_out_ready` is high, and a newer code replaces one not yet sent.
- R7: In software mode, a received 0x13 pauses outbound data and a received 0x11 resumes it, one edge later. Neither code is forwarded. All other bytes, and every byte when software mode is off, appear on `rx_out_*` one edge after they are presented.
- R8: `ovf_flag` is set one edge after `in_ovf_evt`, or one edge after a byte is forwarded on `rx_out_valid` while `in_level` is at or above the inbound capacity. It stays set until a `cfg_ovf_clr` pulse with no new overflow on the same edge.
- R9: `cfg_deep_in`=0 gives 256 inbound and 256 outbound bytes. `cfg_deep_in`=1 gives 384 inbound and 128 outbound bytes. Both values appear on `in_cap`/`out_cap`.
- R10: Turning software mode off clears a pause set by a received stop code on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hw_en | input | 1 | Enable line-based flow control |
| cfg_sw_en | input | 1 | Enable character-based flow control |
| cfg_pol_high | input | 1 | 1: lines asserted high; 0: asserted low |
| cfg_deep_in | input | 1 | 1: larger inbound share |
| cfg_high_mark | input | LVL_W | Upper fill mark |
| cfg_low_mark | input | LVL_W | Lower fill mark |
| cfg_ovf_clr | input | 1 | Clear pulse for the overflow flag |
| in_level | input | LVL_W | Inbound buffer fill count |
| in_ovf_evt | input | 1 | Overflow event from the inbound buffer |
| in_cap | output | LVL_W | Inbound capacity in bytes |
| out_cap | output | LVL_W | Outbound capacity in bytes |
| ovf_flag | output | 1 | Sticky overflow flag |
| tx_in_valid | input | 1 | Outbound data byte offered |
| tx_in_data | input | DATA_W | Outbound data byte |
| tx_in_ready | output | 1 | Outbound data byte taken |
| tx_out_valid | output | 1 | Byte offered to the serialiser |
| tx_out_data | output | DATA_W | Byte to the serialiser |
| tx_out_ready | input | 1 | Serialiser takes the byte |
| rx_in_valid | input | 1 | Received byte from the deserialiser |
| rx_in_data | input | DATA_W | Received byte |
| rx_out_valid | output | 1 | Byte written to the inbound buffer |
| rx_out_data | output | DATA_W | Byte to the inbound buffer |
| rts_pin | output | 1 | Request-to-send line |
| cts_pin | input | 1 | Clear-to-send line |

## Verification
The hold state, the request line and a queued control code change one rising edge after the level that caused them. A forwarded or consumed receive byte and a received pause or resume act one edge after presentation. The overflow flag follows an event pulse by one edge, and a stored byte by two, because the byte first passes through the receive register. A clear-to-send change takes SYNC_STAGES edges, while `tx_in_ready`, `tx_out_*`, `in_cap` and `out_cap` respond to inputs within the same cycle. The bench drives every input on a falling edge and compares on a later falling edge after counting exactly those rising edges. It sweeps the fill level up and down over several mark pairs, both polarities and both buffer splits, and checks the request line at every step against an arithmetic model.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

   typedef enum logic {
      CODE_RESUME = 1'b0,
      CODE_STOP   = 1'b1
   } ctrl_kind_e;

   function automatic logic [7:0] ctrl_byte(input ctrl_kind_e kind,
                                            input logic [7:0] resume_code,
                                            input logic [7:0] stop_code);
      return (kind == CODE_STOP) ? stop_code : resume_code;
   endfunction

endpackage

// File: rtl/sfg_line_sync.sv
module sfg_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   input  logic pol_high,
   output logic asserted
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sfg_line_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= raw_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], raw_in};
         end
      end
   endgenerate

   assign asserted = pol_high ? chain[STAGES-1] : ~chain[STAGES-1];

endmodule

// File: rtl/sfg_level_watch.sv
module sfg_level_watch #(
   parameter int LVL_W       = 9,
   parameter int DEPTH_SMALL = 256,
   parameter int DEPTH_LARGE = 384,
   parameter int BUF_TOTAL   = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] high_mark,
   input  logic [LVL_W-1:0] low_mark,
   input  logic             deep_sel,
   input  logic             ovf_evt,
   input  logic             ovf_clr,
   input  logic             byte_stored,
   output logic             hold_req,
   output logic             hold_rise,
   output logic             hold_fall,
   output logic             ovf_flag,
   output logic [LVL_W-1:0] in_cap,
   output logic [LVL_W-1:0] out_cap
);

   localparam int LVL_MAX = (1 << LVL_W) - 1;

   generate
      if (DEPTH_SMALL >= DEPTH_LARGE) begin : g_bad_order
         $error("sfg_level_watch: DEPTH_SMALL must be below DEPTH_LARGE");
      end
      if (DEPTH_LARGE >= BUF_TOTAL) begin : g_bad_total
         $error("sfg_level_watch: DEPTH_LARGE must be below BUF_TOTAL");
      end
      if (DEPTH_LARGE > LVL_MAX || (BUF_TOTAL - DEPTH_SMALL) > LVL_MAX) begin : g_bad_width
         $error("sfg_level_watch: LVL_W too narrow for the capacities");
      end
   endgenerate

   localparam logic [LVL_W-1:0] IN_SMALL  = LVL_W'(DEPTH_SMALL);
   localparam logic [LVL_W-1:0] IN_LARGE  = LVL_W'(DEPTH_LARGE);
   localparam logic [LVL_W-1:0] OUT_WIDE  = LVL_W'(BUF_TOTAL - DEPTH_SMALL);
   localparam logic [LVL_W-1:0] OUT_NARROW = LVL_W'(BUF_TOTAL - DEPTH_LARGE);

   logic [LVL_W-1:0] eff_high;
   logic             hold_next;
   logic             ovf_hit;

   assign in_cap   = deep_sel ? IN_LARGE : IN_SMALL;
   assign out_cap  = deep_sel ? OUT_NARROW : OUT_WIDE;
   assign eff_high = (high_mark < in_cap) ? high_mark : in_cap;

   always_comb begin
      hold_next = hold_req;
      if (level >= eff_high)      hold_next = 1'b1;
      else if (level <= low_mark) hold_next = 1'b0;
   end

   assign hold_rise = hold_next & ~hold_req;
   assign hold_fall = ~hold_next & hold_req;
   assign ovf_hit   = ovf_evt | (byte_stored & (level >= in_cap));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_req <= 1'b0;
         ovf_flag <= 1'b0;
      end else begin
         hold_req <= hold_next;
         if (ovf_hit)      ovf_flag <= 1'b1;
         else if (ovf_clr) ovf_flag <= 1'b0;
      end
   end

   a_r2_high_sets_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (level >= eff_high) |=> hold_req);

   a_r3_low_clears_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (level <= low_mark && level < eff_high) |=> !hold_req);

   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);

   a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_flag);

endmodule

// File: rtl/sfg_rx_filter.sv
module sfg_rx_filter #(
   parameter int          DATA_W      = 8,
   parameter logic [7:0]  RESUME_CODE = 8'h11,
   parameter logic [7:0]  STOP_CODE   = 8'h13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_en,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              remote_hold
);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("sfg_rx_filter: DATA_W must hold an 8-bit code");
      end
   endgenerate

   logic is_stop;
   logic is_resume;
   logic consume;

   assign is_stop   = in_valid && (in_data[7:0] == STOP_CODE);
   assign is_resume = in_valid && (in_data[7:0] == RESUME_CODE);
   assign consume   = sw_en && (is_stop || is_resume);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_data    <= '0;
         remote_hold <= 1'b0;
      end else begin
         out_valid <= in_valid && !consume;
         if (in_valid) out_data <= in_data;
         if (!sw_en)         remote_hold <= 1'b0;
         else if (is_stop)   remote_hold <= 1'b1;
         else if (is_resume) remote_hold <= 1'b0;
      end
   end

   a_r7_codes_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && (is_stop || is_resume)) |=> !out_valid);

   a_r7_stop_pauses: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && is_stop) |=> remote_hold);

   a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en |=> !remote_hold);

endmodule

// File: rtl/sfg_tx_mux.sv
module sfg_tx_mux #(
   parameter int          DATA_W      = 8,
   parameter logic [7:0]  RESUME_CODE = 8'h11,
   parameter logic [7:0]  STOP_CODE   = 8'h13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_stop,
   input  logic              load_resume,
   input  logic              paused,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready
);

   import sfg_pkg::*;

   logic       pend_valid;
   ctrl_kind_e pend_kind;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_kind  <= CODE_RESUME;
      end else begin
         if (load_stop || load_resume) begin
            pend_valid <= 1'b1;
            pend_kind  <= load_stop ? CODE_STOP : CODE_RESUME;
         end else if (pend_valid && out_ready) begin
            pend_valid <= 1'b0;
         end
      end
   end

   assign out_valid = pend_valid | (~paused & in_valid);
   assign out_data  = pend_valid ? DATA_W'(ctrl_byte(pend_kind, RESUME_CODE, STOP_CODE))
                                 : in_data;
   assign in_ready  = ~pend_valid & ~paused & out_ready;

   a_r6_code_retires: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_valid && out_ready && !load_stop && !load_resume) |=> !pend_valid);

   a_r6_code_first: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stop || load_resume) |=> (out_valid && !in_ready));

   a_r5_pause_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && !pend_valid) |-> !in_ready);

endmodule

// File: rtl/serial_flow_gate.sv
module serial_flow_gate #(
   parameter int          LVL_W       = 9,
   parameter int          DATA_W      = 8,
   parameter int          DEPTH_SMALL = 256,
   parameter int          DEPTH_LARGE = 384,
   parameter int          BUF_TOTAL   = 512,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  RESUME_CODE = 8'h11,
   parameter logic [7:0]  STOP_CODE   = 8'h13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_hw_en,
   input  logic              cfg_sw_en,
   input  logic              cfg_pol_high,
   input  logic              cfg_deep_in,
   input  logic [LVL_W-1:0]  cfg_high_mark,
   input  logic [LVL_W-1:0]  cfg_low_mark,
   input  logic              cfg_ovf_clr,
   input  logic [LVL_W-1:0]  in_level,
   input  logic              in_ovf_evt,
   output logic [LVL_W-1:0]  in_cap,
   output logic [LVL_W-1:0]  out_cap,
   output logic              ovf_flag,
   input  logic              tx_in_valid,
   input  logic [DATA_W-1:0] tx_in_data,
   output logic              tx_in_ready,
   output logic              tx_out_valid,
   output logic [DATA_W-1:0] tx_out_data,
   input  logic              tx_out_ready,
   input  logic              rx_in_valid,
   input  logic [DATA_W-1:0] rx_in_data,
   output logic              rx_out_valid,
   output logic [DATA_W-1:0] rx_out_data,
   output logic              rts_pin,
   input  logic              cts_pin
);

   logic hold_req, hold_rise, hold_fall;
   logic cts_ok, sw_hold, paused, rts_asserted;

   sfg_level_watch #(
      .LVL_W(LVL_W), .DEPTH_SMALL(DEPTH_SMALL),
      .DEPTH_LARGE(DEPTH_LARGE), .BUF_TOTAL(BUF_TOTAL)
   ) u_level (
      .clk(clk), .rst_n(rst_n),
      .level(in_level), .high_mark(cfg_high_mark), .low_mark(cfg_low_mark),
      .deep_sel(cfg_deep_in), .ovf_evt(in_ovf_evt), .ovf_clr(cfg_ovf_clr),
      .byte_stored(rx_out_valid),
      .hold_req(hold_req), .hold_rise(hold_rise), .hold_fall(hold_fall),
      .ovf_flag(ovf_flag), .in_cap(in_cap), .out_cap(out_cap)
   );

   sfg_line_sync #(.STAGES(SYNC_STAGES)) u_cts (
      .clk(clk), .rst_n(rst_n), .raw_in(cts_pin),
      .pol_high(cfg_pol_high), .asserted(cts_ok)
   );

   sfg_rx_filter #(
      .DATA_W(DATA_W), .RESUME_CODE(RESUME_CODE), .STOP_CODE(STOP_CODE)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .sw_en(cfg_sw_en),
      .in_valid(rx_in_valid), .in_data(rx_in_data),
      .out_valid(rx_out_valid), .out_data(rx_out_data),
      .remote_hold(sw_hold)
   );

   assign paused = (cfg_hw_en & ~cts_ok) | (cfg_sw_en & sw_hold);

   sfg_tx_mux #(
      .DATA_W(DATA_W), .RESUME_CODE(RESUME_CODE), .STOP_CODE(STOP_CODE)
   ) u_tx (
      .clk(clk), .rst_n(rst_n),
      .load_stop(cfg_sw_en & hold_rise), .load_resume(cfg_sw_en & hold_fall),
      .paused(paused),
      .in_valid(tx_in_valid), .in_data(tx_in_data), .in_ready(tx_in_ready),
      .out_valid(tx_out_valid), .out_data(tx_out_data), .out_ready(tx_out_ready)
   );

   assign rts_asserted = ~(cfg_hw_en & hold_req);
   assign rts_pin      = cfg_pol_high ? rts_asserted : ~rts_asserted;

   a_r4_rts_follows_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hw_en && in_level >= in_cap) |=> (rts_pin != cfg_pol_high));

   a_r5_no_data_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_in_valid && tx_in_ready) |-> (tx_out_valid && tx_out_data == tx_in_data));

endmodule

// File: tb/sim_serial_flow_gate.sv
module sim_serial_flow_gate;

   localparam int CLK_PER = 10;
   localparam int LVL_W   = 9;
   localparam int DATA_W  = 8;
   localparam int SYNC    = 2;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cfg_hw_en, cfg_sw_en, cfg_pol_high, cfg_deep_in, cfg_ovf_clr;
   logic [LVL_W-1:0]  cfg_high_mark, cfg_low_mark, in_level;
   logic              in_ovf_evt;
   logic [LVL_W-1:0]  in_cap, out_cap;
   logic              ovf_flag;
   logic              tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready;
   logic [DATA_W-1:0] tx_in_data, tx_out_data;
   logic              rx_in_valid, rx_out_valid;
   logic [DATA_W-1:0] rx_in_data, rx_out_data;
   logic              rts_pin, cts_pin;

   int vectors = 0;
   int fails   = 0;

   always #(CLK_PER/2) clk = ~clk;

   serial_flow_gate u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_hw_en(cfg_hw_en), .cfg_sw_en(cfg_sw_en), .cfg_pol_high(cfg_pol_high),
      .cfg_deep_in(cfg_deep_in), .cfg_high_mark(cfg_high_mark),
      .cfg_low_mark(cfg_low_mark), .cfg_ovf_clr(cfg_ovf_clr),
      .in_level(in_level), .in_ovf_evt(in_ovf_evt),
      .in_cap(in_cap), .out_cap(out_cap), .ovf_flag(ovf_flag),
      .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_ready(tx_in_ready),
      .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
      .tx_out_ready(tx_out_ready),
      .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
      .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
      .rts_pin(rts_pin), .cts_pin(cts_pin)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int caps[2];
      int highs[4];
      int lows[4];
      int cap, eff, lvl;
      logic hold;
      caps[0] = 256; caps[1] = 384;
      highs[0] = 200; lows[0] = 100;
      highs[1] = 64;  lows[1] = 64;
      highs[2] = 450; lows[2] = 20;
      highs[3] = 40;  lows[3] = 90;

      rst_n = 1'b0;
      cfg_hw_en = 1'b1; cfg_sw_en = 1'b0; cfg_pol_high = 1'b0; cfg_deep_in = 1'b0;
      cfg_ovf_clr = 1'b0; cfg_high_mark = 9'd200; cfg_low_mark = 9'd100;
      in_level = '0; in_ovf_evt = 1'b0;
      tx_in_valid = 1'b0; tx_in_data = 8'hA5; tx_out_ready = 1'b1;
      rx_in_valid = 1'b0; rx_in_data = 8'h00; cts_pin = 1'b0;
      step(3);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 rts", {15'd0, rts_pin}, 16'd0);
      chk("R1 ovf", {15'd0, ovf_flag}, 16'd0);
      chk("R1 tx_out_valid", {15'd0, tx_out_valid}, 16'd0);
      chk("R1 rx_out_valid", {15'd0, rx_out_valid}, 16'd0);
      chk("R1 tx_in_ready", {15'd0, tx_in_ready}, 16'd1);

      // R9 capacity split
      cfg_deep_in = 1'b0; #1;
      chk("R9 in_cap small", 16'(in_cap), 16'd256);
      chk("R9 out_cap wide", 16'(out_cap), 16'd256);
      cfg_deep_in = 1'b1; #1;
      chk("R9 in_cap large", 16'(in_cap), 16'd384);
      chk("R9 out_cap narrow", 16'(out_cap), 16'd128);
      step(1);

      // R2 R3 R4 sweep of level, marks, polarity, split
      for (int pol = 0; pol < 2; pol++) begin
         for (int dp = 0; dp < 2; dp++) begin
            for (int mp = 0; mp < 4; mp++) begin
               cfg_pol_high = pol[0]; cfg_deep_in = dp[0];
               cap = caps[dp];
               cfg_high_mark = LVL_W'(highs[mp]); cfg_low_mark = LVL_W'(lows[mp]);
               eff = (highs[mp] < cap) ? highs[mp] : cap;
               in_level = '0;
               step(1);
               hold = 1'b0;
               for (int k = 0; k < 302; k++) begin
                  lvl = (k < 151) ? k * 3 : (301 - k) * 3;
                  in_level = LVL_W'(lvl);
                  if (lvl >= eff)             hold = 1'b1;
                  else if (lvl <= lows[mp])   hold = 1'b0;
                  step(1);
                  chk(hold ? "R2 rts held off" : "R3 rts released",
                      {15'd0, rts_pin}, {15'd0, (pol[0] ? ~hold : hold)});
               end
            end
         end
      end

      // R4 hardware mode off keeps rts asserted
      in_level = 9'd300; cfg_high_mark = 9'd10; cfg_hw_en = 1'b0;
      for (int pol = 0; pol < 2; pol++) begin
         cfg_pol_high = pol[0];
         step(1);
         chk("R4 rts idle level", {15'd0, rts_pin}, {15'd0, pol[0]});
      end

      // R5 CTS pause with synchroniser delay
      cfg_hw_en = 1'b1; cfg_pol_high = 1'b0; cfg_deep_in = 1'b0;
      cfg_high_mark = 9'd200; cfg_low_mark = 9'd100; in_level = '0;
      cts_pin = 1'b0; tx_in_valid = 1'b1; tx_in_data = 8'h5A; tx_out_ready = 1'b1;
      step(3);
      chk("R5 ready before", {15'd0, tx_in_ready}, 16'd1);
      cts_pin = 1'b1;
      step(SYNC - 1);
      chk("R5 ready during sync", {15'd0, tx_in_ready}, 16'd1);
      step(1);
      chk("R5 ready blocked", {15'd0, tx_in_ready}, 16'd0);
      chk("R5 no data out", {15'd0, tx_out_valid}, 16'd0);
      cfg_pol_high = 1'b1; #1;
      chk("R4 cts active high", {15'd0, tx_in_ready}, 16'd1);
      step(1);
      cts_pin = 1'b0;
      step(SYNC - 1);
      chk("R5 still running", {15'd0, tx_in_ready}, 16'd1);
      step(1);
      chk("R5 blocked high pol", {15'd0, tx_in_ready}, 16'd0);
      cts_pin = 1'b1;
      step(SYNC);
      chk("R5 resumed", {15'd0, tx_in_ready}, 16'd1);
      chk("R5 data passes", 16'(tx_out_data), 16'h5A);

      // R6 R7 R10 software mode
      cfg_hw_en = 1'b0; cfg_sw_en = 1'b1; cfg_high_mark = 9'd20; cfg_low_mark = 9'd10;
      in_level = '0; tx_out_ready = 1'b0; tx_in_data = 8'hA5;
      step(1);
      in_level = 9'd25;
      step(1);
      chk("R6 stop offered", {15'd0, tx_out_valid}, 16'd1);
      chk("R6 stop code", 16'(tx_out_data), 16'h13);
      chk("R6 data held back", {15'd0, tx_in_ready}, 16'd0);
      tx_out_ready = 1'b1;
      step(1);
      chk("R6 stop retired", 16'(tx_out_data), 16'hA5);
      chk("R6 data flows", {15'd0, tx_in_ready}, 16'd1);
      rx_in_valid = 1'b1; rx_in_data = 8'h13;
      step(1);
      rx_in_valid = 1'b0;
      chk("R7 stop consumed", {15'd0, rx_out_valid}, 16'd0);
      chk("R7 paused ready", {15'd0, tx_in_ready}, 16'd0);
      chk("R7 paused valid", {15'd0, tx_out_valid}, 16'd0);
      in_level = 9'd5;
      step(1);
      chk("R6 resume while paused", {15'd0, tx_out_valid}, 16'd1);
      chk("R6 resume code", 16'(tx_out_data), 16'h11);
      step(1);
      chk("R6 resume retired", {15'd0, tx_out_valid}, 16'd0);
      rx_in_valid = 1'b1; rx_in_data = 8'h11;
      step(1);
      chk("R7 resume consumed", {15'd0, rx_out_valid}, 16'd0);
      chk("R7 resumed", {15'd0, tx_in_ready}, 16'd1);
      rx_in_data = 8'h41;
      step(1);
      chk("R7 plain byte", {15'd0, rx_out_valid}, 16'd1);
      chk("R7 plain data", 16'(rx_out_data), 16'h41);
      rx_in_data = 8'h13;
      step(1);
      rx_in_valid = 1'b0;
      chk("R7 stop pauses again", {15'd0, tx_in_ready}, 16'd0);
      cfg_sw_en = 1'b0;
      step(1);
      chk("R10 pause dropped", {15'd0, tx_in_ready}, 16'd1);
      rx_in_valid = 1'b1; rx_in_data = 8'h13;
      step(1);
      rx_in_valid = 1'b0;
      chk("R7 code forwarded off", {15'd0, rx_out_valid}, 16'd1);
      chk("R7 code data off", 16'(rx_out_data), 16'h13);
      // replacement of an unsent code
      cfg_sw_en = 1'b1; tx_out_ready = 1'b0; in_level = 9'd25;
      step(1);
      in_level = 9'd5;
      step(1);
      chk("R6 newer code replaces", 16'(tx_out_data), 16'h11);
      tx_out_ready = 1'b1;
      step(1);
      chk("R6 single code sent", {15'd0, tx_in_ready}, 16'd1);
      cfg_sw_en = 1'b0;
      step(1);

      // R8 overflow
      cfg_deep_in = 1'b0; in_level = 9'd255;
      rx_in_valid = 1'b1; rx_in_data = 8'h55;
      step(1);
      rx_in_valid = 1'b0;
      step(1);
      chk("R8 below capacity", {15'd0, ovf_flag}, 16'd0);
      in_level = 9'd256; rx_in_valid = 1'b1;
      step(1);
      rx_in_valid = 1'b0;
      chk("R8 byte stored", {15'd0, rx_out_valid}, 16'd1);
      step(1);
      chk("R8 full store sets", {15'd0, ovf_flag}, 16'd1);
      step(3);
      chk("R8 sticky", {15'd0, ovf_flag}, 16'd1);
      cfg_ovf_clr = 1'b1;
      step(1);
      cfg_ovf_clr = 1'b0;
      chk("R8 cleared", {15'd0, ovf_flag}, 16'd0);
      in_ovf_evt = 1'b1;
      step(1);
      in_ovf_evt = 1'b0;
      chk("R8 event sets", {15'd0, ovf_flag}, 16'd1);
      cfg_ovf_clr = 1'b1; in_ovf_evt = 1'b1;
      step(1);
      cfg_ovf_clr = 1'b0; in_ovf_evt = 1'b0;
      chk("R8 set wins", {15'd0, ovf_flag}, 16'd1);
      cfg_ovf_clr = 1'b1;
      step(1);
      cfg_ovf_clr = 1'b0;
      cfg_deep_in = 1'b1; in_level = 9'd300; rx_in_valid = 1'b1;
      step(1);
      rx_in_valid = 1'b0;
      step(1);
      chk("R9 large share no overflow", {15'd0, ovf_flag}, 16'd0);
      in_level = 9'd384; rx_in_valid = 1'b1;
      step(1);
      rx_in_valid = 1'b0;
      step(1);
      chk("R9 large share full", {15'd0, ovf_flag}, 16'd1);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule